// File: doc/BRIEF.md
# Audio Routing Control Target

This block is the serial control front end of a three-channel stereo routing device. It listens on a two-wire bus (SCL and SDA, I2C protocol) as a write-only target and answers with an open-drain acknowledge. It keeps one 8-bit setting per output channel and decodes each setting into signals for the analog side. The low nibble of a setting picks one of nine sources or silences the channel. The high nibble is a gain step for the channel's amplifier.

A bus write has a fixed shape. It starts with START and the device address with the direction bit clear. A register pointer byte follows, then any number of data bytes, and the write ends with STOP. The target acknowledges each accepted byte. After each data byte the pointer steps forward and wraps after the last channel, so one write can load all three channels.

A strap pin picks one of two device addresses, so two devices can share one bus. The bus lines are resampled on a fast system clock. START and STOP are found as SDA edges while SCL is high.

Top module: `chsel_i2c_target`

## Requirements
- R1: The 8-bit address byte, direction bit included, is 94h when `addr_sel_i` is low and 96h when it is high. On a match the target pulls SDA low (`sda_oe_o`=1) for the ninth clock of that byte, and only while SCL is low at the moment the pull starts and stops.
- R2: An address byte with the direction bit set (95h/97h), or with a different address, gets no acknowledge. The bytes that follow it are ignored until the next START.
- R3: After reset all three settings are 00h. Every channel then shows mute=1, a select vector of zero and a gain of zero.
- R4: The byte after a matched address is the register pointer and is acknowledged. Each following data byte is acknowledged and is stored in the setting the pointer names (00h, 01h or 02h for channels 0, 1 and 2).
- R5: After each stored data byte the pointer steps 00h, then 01h, then 02h, then back to 00h.
- R6: A pointer value of 03h or above is acknowledged, and so are the data bytes after it. Those data bytes change no setting until a new write brings a valid pointer.
- R7: For a setting code c = D3..D0 in the range 1 to 9, the channel's 9-bit select vector has only bit c-1 set, and mute is 0.
- R8: A code D3..D0 of 0, or of 10 to 15, gives mute=1 and a select vector of zero.
- R9: The gain output is D7..D4 when that value is 11 (1011b) or less. Larger values come out as 11.
- R10: Decoded outputs change only in the cycle the acknowledge of a complete data byte ends. They stay steady while the bits of that byte are shifting in.
- R11: A STOP or a repeated START in the middle of a byte drops that partial byte. A repeated START begins a new address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel_i | input | 1 | Address strap: 0 gives 94h, 1 gives 96h |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge) |
| route_sel_o | output | 27 | One-hot source select, 9 bits per channel, channel 0 in the low bits |
| route_mute_o | output | 3 | Mute flag per channel |
| gain_code_o | output | 12 | 4-bit gain code per channel, channel 0 in the low bits |

## Verification
The decoder is tried on all sixteen low-nibble and high-nibble codes on one channel. This separates the nine select positions from the mute codes at both ends and the passed gain codes from the clamped ones. Writes of one, two and three bytes start from different pointers, which shows wrap-around as distinct from a plain increment. Reads, foreign addresses, an out-of-range pointer and bytes cut short by STOP or by a repeated START are each followed by a check that the outputs did not move, which tells ignored traffic from stored traffic. Both strap settings are used, so a target that answers to a fixed address is caught.

// File: rtl/chsel_pkg.sv
package chsel_pkg;
    localparam int REG_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SHIFT,
        PH_ACK,
        PH_DROP
    } phase_e;

    typedef enum logic [1:0] {
        BK_ADDR,
        BK_PTR,
        BK_DATA
    } byte_kind_e;
endpackage

// File: rtl/chsel_bus_sync.sv
module chsel_bus_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic sda_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic [1:0] scl_m;
        logic [1:0] sda_m;
        logic       scl_p;
        logic       sda_p;
    } smp_t;

    smp_t q, d;

    always_comb begin
        d       = q;
        d.scl_m = {q.scl_m[0], scl_i};
        d.sda_m = {q.sda_m[0], sda_i};
        d.scl_p = q.scl_m[1];
        d.sda_p = q.sda_m[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign sda_o      = q.sda_m[1];
    assign scl_rise_o = q.scl_m[1] & ~q.scl_p;
    assign scl_fall_o = ~q.scl_m[1] & q.scl_p;
    assign start_o    = q.scl_m[1] & q.scl_p & q.sda_p & ~q.sda_m[1];
    assign stop_o     = q.scl_m[1] & q.scl_p & ~q.sda_p & q.sda_m[1];
endmodule

// File: rtl/chsel_byte_engine.sv
module chsel_byte_engine
    import chsel_pkg::*;
#(
    parameter int          N_CH     = 3,
    parameter logic [5:0]  ADDR_HI6 = 6'h25
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_rise_i,
    input  logic                  scl_fall_i,
    input  logic                  sda_i,
    input  logic                  start_i,
    input  logic                  stop_i,
    input  logic                  strap_i,
    output logic                  ack_oe_o,
    output logic [N_CH*REG_W-1:0] regs_o
);
    localparam int PTR_W = (N_CH > 1) ? $clog2(N_CH) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(N_CH - 1);

    typedef struct packed {
        phase_e                  ph;
        byte_kind_e              kind;
        logic [REG_W-1:0]        sh;
        logic [3:0]              cnt;
        logic                    ack_oe;
        logic [PTR_W-1:0]        ptr;
        logic                    ptr_ok;
        logic [N_CH*REG_W-1:0]   regs;
    } eng_t;

    localparam eng_t ENG_RST = '{
        ph: PH_IDLE, kind: BK_ADDR, sh: '0, cnt: '0,
        ack_oe: 1'b0, ptr: '0, ptr_ok: 1'b0, regs: '0
    };

    eng_t q, d;

    always_comb begin
        d = q;
        unique case (q.ph)
            PH_SHIFT: begin
                if (scl_rise_i && q.cnt < 4'd8) begin
                    d.sh  = {q.sh[REG_W-2:0], sda_i};
                    d.cnt = q.cnt + 4'd1;
                end else if (scl_fall_i && q.cnt == 4'd8) begin
                    unique case (q.kind)
                        BK_ADDR: begin
                            if (q.sh[7:1] == {ADDR_HI6, strap_i} && !q.sh[0]) begin
                                d.ack_oe = 1'b1;
                                d.ph     = PH_ACK;
                            end else begin
                                d.ph     = PH_DROP;
                            end
                        end
                        BK_PTR: begin
                            d.ack_oe = 1'b1;
                            d.ph     = PH_ACK;
                            d.ptr_ok = (32'(q.sh) < N_CH);
                            d.ptr    = q.sh[PTR_W-1:0];
                        end
                        default: begin
                            d.ack_oe = 1'b1;
                            d.ph     = PH_ACK;
                        end
                    endcase
                end
            end
            PH_ACK: begin
                if (scl_fall_i) begin
                    d.ack_oe = 1'b0;
                    d.ph     = PH_SHIFT;
                    d.cnt    = '0;
                    unique case (q.kind)
                        BK_ADDR: d.kind = BK_PTR;
                        BK_PTR:  d.kind = BK_DATA;
                        default: begin
                            if (q.ptr_ok) begin
                                d.regs[int'(q.ptr)*REG_W +: REG_W] = q.sh;
                                d.ptr = (q.ptr == PTR_LAST) ? '0 : q.ptr + 1'b1;
                            end
                        end
                    endcase
                end
            end
            default: ;
        endcase

        if (start_i) begin
            d.ph     = PH_SHIFT;
            d.kind   = BK_ADDR;
            d.cnt    = '0;
            d.ack_oe = 1'b0;
        end else if (stop_i) begin
            d.ph     = PH_IDLE;
            d.ack_oe = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= ENG_RST;
        else        q <= d;
    end

    assign ack_oe_o = q.ack_oe;
    assign regs_o   = q.regs;
endmodule

// File: rtl/chsel_chan_decode.sv
module chsel_chan_decode #(
    parameter int N_IN     = 9,
    parameter int GAIN_MAX = 11
) (
    input  logic [7:0]      cfg_i,
    output logic [N_IN-1:0] sel_o,
    output logic            mute_o,
    output logic [3:0]      gain_o
);
    localparam logic [3:0] GAIN_TOP = 4'(GAIN_MAX);

    always_comb begin
        sel_o  = '0;
        mute_o = 1'b1;
        for (int k = 0; k < N_IN; k++) begin
            if (cfg_i[3:0] == 4'(k + 1)) begin
                sel_o[k] = 1'b1;
                mute_o   = 1'b0;
            end
        end
        gain_o = (cfg_i[7:4] > GAIN_TOP) ? GAIN_TOP : cfg_i[7:4];
    end
endmodule

// File: rtl/chsel_i2c_target.sv
module chsel_i2c_target
    import chsel_pkg::*;
#(
    parameter int         N_CH     = 3,
    parameter int         N_IN     = 9,
    parameter int         GAIN_MAX = 11,
    parameter logic [5:0] ADDR_HI6 = 6'h25
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 addr_sel_i,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output logic                 sda_oe_o,
    output logic [N_CH*N_IN-1:0] route_sel_o,
    output logic [N_CH-1:0]      route_mute_o,
    output logic [N_CH*4-1:0]    gain_code_o
);
    logic scl_rise, scl_fall, sda_s, start_p, stop_p;
    logic [N_CH*REG_W-1:0] regs;

    chsel_bus_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .sda_o      (sda_s),
        .start_o    (start_p),
        .stop_o     (stop_p)
    );

    chsel_byte_engine #(.N_CH(N_CH), .ADDR_HI6(ADDR_HI6)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .sda_i      (sda_s),
        .start_i    (start_p),
        .stop_i     (stop_p),
        .strap_i    (addr_sel_i),
        .ack_oe_o   (sda_oe_o),
        .regs_o     (regs)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_chan
        chsel_chan_decode #(.N_IN(N_IN), .GAIN_MAX(GAIN_MAX)) u_dec (
            .cfg_i  (regs[c*REG_W +: REG_W]),
            .sel_o  (route_sel_o[c*N_IN +: N_IN]),
            .mute_o (route_mute_o[c]),
            .gain_o (gain_code_o[c*4 +: 4])
        );
    end
endmodule

// File: rtl/chsel_checker.sv
module chsel_checker #(
    parameter int N_CH     = 3,
    parameter int N_IN     = 9,
    parameter int GAIN_MAX = 11
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 scl_i,
    input logic                 sda_oe_o,
    input logic [N_CH*N_IN-1:0] route_sel_o,
    input logic [N_CH-1:0]      route_mute_o,
    input logic [N_CH*4-1:0]    gain_code_o
);
    assert_ack_edge_scl_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe_o) || $fell(sda_oe_o)) |-> !scl_i);

    assert_outputs_move_on_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(route_sel_o) || !$stable(gain_code_o) || !$stable(route_mute_o))
            |-> $fell(sda_oe_o));

    for (genvar c = 0; c < N_CH; c++) begin : g_chk
        assert_sel_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !route_mute_o[c] |-> ($countones(route_sel_o[c*N_IN +: N_IN]) == 1));

        assert_mute_clears_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
            route_mute_o[c] |-> (route_sel_o[c*N_IN +: N_IN] == '0));

        assert_gain_clamped_R9: assert property (@(posedge clk) disable iff (!rst_n)
            32'(gain_code_o[c*4 +: 4]) <= GAIN_MAX);
    end
endmodule

bind chsel_i2c_target chsel_checker #(.N_CH(N_CH), .N_IN(N_IN), .GAIN_MAX(GAIN_MAX)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl_i),
    .sda_oe_o     (sda_oe_o),
    .route_sel_o  (route_sel_o),
    .route_mute_o (route_mute_o),
    .gain_code_o  (gain_code_o)
);

// File: tb/sim_chsel_i2c_target.sv
module sim_chsel_i2c_target;
    localparam int Q = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap = 1'b0;
    logic        scl = 1'b1;
    logic        sda_drv = 1'b1;
    logic        sda_oe;
    logic [26:0] sel;
    logic [2:0]  mute;
    logic [11:0] gain;
    logic        sda_line;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [7:0] mdl [3];

    assign sda_line = sda_drv & ~sda_oe;

    always #2.5 clk = ~clk;

    chsel_i2c_target u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr_sel_i   (strap),
        .scl_i        (scl),
        .sda_i        (sda_line),
        .sda_oe_o     (sda_oe),
        .route_sel_o  (sel),
        .route_mute_o (mute),
        .gain_code_o  (gain)
    );

    task automatic waitq(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [8:0] exp_sel(input logic [7:0] v);
        if (v[3:0] >= 4'd1 && v[3:0] <= 4'd9) return 9'(1) << (v[3:0] - 4'd1);
        return '0;
    endfunction

    function automatic logic [3:0] exp_gain(input logic [7:0] v);
        return (v[7:4] > 4'd11) ? 4'd11 : v[7:4];
    endfunction

    task automatic check_outputs(input string scen);
        for (int c = 0; c < 3; c++) begin
            chk({scen, " R7 select"}, 32'(sel[c*9 +: 9]), 32'(exp_sel(mdl[c])));
            chk({scen, " R8 mute"}, 32'(mute[c]), 32'(exp_sel(mdl[c]) == 0));
            chk({scen, " R9 gain"}, 32'(gain[c*4 +: 4]), 32'(exp_gain(mdl[c])));
        end
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; waitq(1);
        scl = 1'b1;     waitq(1);
        sda_drv = 1'b0; waitq(1);
        scl = 1'b0;     waitq(1);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; waitq(1);
        scl = 1'b1;     waitq(1);
        sda_drv = 1'b1; waitq(2);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_drv = b[i]; waitq(1);
            scl = 1'b1;     waitq(2);
            scl = 1'b0;     waitq(1);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        logic [26:0] s0;
        logic [11:0] g0;
        s0 = sel;
        g0 = gain;
        send_bits(b, 8);
        sda_drv = 1'b1; waitq(1);
        scl = 1'b1;     waitq(1);
        ack = !sda_line;
        waitq(1);
        chk("R10 select steady during byte", 32'(sel), 32'(s0));
        chk("R10 gain steady during byte", 32'(gain), 32'(g0));
        scl = 1'b0;     waitq(1);
    endtask

    task automatic wr(input logic [7:0] ptr, input int n,
                      input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
        bit a;
        logic [7:0] dv [3];
        int p;
        dv[0] = d0; dv[1] = d1; dv[2] = d2;
        bus_start();
        send_byte({6'h25, strap, 1'b0}, a);
        chk("R1 address acknowledged", 32'(a), 1);
        send_byte(ptr, a);
        chk("R4 pointer acknowledged", 32'(a), 1);
        p = int'(ptr);
        for (int i = 0; i < n; i++) begin
            send_byte(dv[i], a);
            chk("R4 data acknowledged", 32'(a), 1);
            if (ptr < 8'd3) begin
                mdl[p] = dv[i];
                p = (p + 1) % 3;
            end
        end
        bus_stop();
    endtask

    task automatic t_reset();
        check_outputs("R3 reset");
        chk("R3 no acknowledge drive", 32'(sda_oe), 0);
    endtask

    task automatic t_basic();
        strap = 1'b0;
        wr(8'h00, 1, 8'h53, 8'h00, 8'h00);
        check_outputs("R4 write ch0 strap low");
        strap = 1'b1;
        wr(8'h02, 1, 8'hB9, 8'h00, 8'h00);
        check_outputs("R1 write ch2 strap high");
    endtask

    task automatic t_reject();
        bit a;
        strap = 1'b1;
        bus_start();
        send_byte(8'h94, a);
        chk("R2 other address not acknowledged", 32'(a), 0);
        send_byte(8'h00, a);
        send_byte(8'h77, a);
        chk("R2 ignored byte not acknowledged", 32'(a), 0);
        bus_stop();
        check_outputs("R2 after foreign address");
        bus_start();
        send_byte(8'h97, a);
        chk("R2 read not acknowledged", 32'(a), 0);
        send_byte(8'h01, a);
        send_byte(8'h44, a);
        bus_stop();
        check_outputs("R2 after read request");
    endtask

    task automatic t_autoinc();
        strap = 1'b0;
        wr(8'h01, 3, 8'h21, 8'h32, 8'h43);
        check_outputs("R5 three bytes from 01h");
        wr(8'h02, 2, 8'h15, 8'h27, 8'h00);
        check_outputs("R5 wrap 02h to 00h");
    endtask

    task automatic t_bad_ptr();
        strap = 1'b0;
        wr(8'h03, 2, 8'h66, 8'h77, 8'h00);
        check_outputs("R6 pointer 03h discards data");
        wr(8'hF0, 1, 8'h88, 8'h00, 8'h00);
        check_outputs("R6 pointer F0h discards data");
        wr(8'h00, 1, 8'h12, 8'h00, 8'h00);
        check_outputs("R6 valid pointer restores writes");
    endtask

    task automatic t_decode();
        strap = 1'b1;
        for (int v = 0; v < 16; v++) begin
            wr(8'h01, 1, {4'(v), 4'(15 - v)}, 8'h00, 8'h00);
            check_outputs("R7 R8 R9 code sweep");
        end
    endtask

    task automatic t_abort();
        bit a;
        strap = 1'b0;
        bus_start();
        send_byte(8'h94, a);
        send_byte(8'h00, a);
        send_bits(8'hFF, 4);
        bus_stop();
        check_outputs("R11 stop mid byte");
        bus_start();
        send_byte(8'h94, a);
        send_byte(8'h01, a);
        send_bits(8'h99, 5);
        bus_start();
        send_byte(8'h94, a);
        chk("R11 repeated start new address", 32'(a), 1);
        send_byte(8'h02, a);
        send_byte(8'h37, a);
        chk("R11 data after repeated start", 32'(a), 1);
        bus_stop();
        mdl[2] = 8'h37;
        check_outputs("R11 repeated start mid byte");
    endtask

    initial begin
        for (int c = 0; c < 3; c++) mdl[c] = 8'h00;
        repeat (6) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_basic();
        t_reject();
        t_autoinc();
        t_bad_ptr();
        t_decode();
        t_abort();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule